// File: doc/BRIEF.md
# Virtual Function Reset Handshake Controller

This block coordinates reset signalling between one physical function (PF) and a set of virtual functions (VFs) in a multi-queue network controller. Each VF owns two receive queues and two transmit queues. VF `n` owns queues `n` and `n + NUM_VF`. When a VF asks to be reset, the block does four things: it turns off that VF's four queues, drops the VF's receive and transmit pool enables, latches a per-VF reset event, and pulses the interrupt cause that the PF mailbox path already uses.

The block also carries the two-flag handshake seen by the VF mailboxes. A device reset marks every VF mailbox as "reset in progress". Later the PF writes its extended control register with the reset-done bit set. That write clears every in-progress flag and sets every done flag.

The PF reaches all of this state through a simple write port made of an enable, a 3-bit register select and a data word. Each VF reset request arrives on its own one-cycle strobe. Every output is registered.

Top module: `vf_reset_ctl`

## Requirements
- R1: One clock edge after `vf_rst_req[n]` is high, `rxq_en` and `txq_en` bits `n` and `n+NUM_VF` are 0. Every other queue bit keeps its value.
- R2: One clock edge after `vf_rst_req[n]` is high, bit `n` of both `pool_rx_en` and `pool_tx_en` is 0. Other pool bits are unchanged.
- R3: One clock edge after `vf_rst_req[n]` is high, `vf_rst_evt[n]` is 1. The bit stays set until the PF clears it.
- R4: `pf_mbx_irq` is high for exactly the cycle that follows any cycle with a nonzero `vf_rst_req`. Otherwise it is low.
- R5: While `rst` is high (synchronous, active high), the block loads its reset state on the clock edge:
  - `rxq_en` and `txq_en` are `1` (only queue 0 enabled).
  - The pool enables, `vf_rst_evt`, `mbx_rst_done` and `ext_ctrl` are 0.
  - `mbx_rst_inprog` is all ones.
- R6: A write with select 0 (extended control) whose data bit 14 is 1 clears every `mbx_rst_inprog` bit and sets every `mbx_rst_done` bit on that edge. A write with select 0 and bit 14 at 0 leaves both flag vectors unchanged.
- R7: A write with select 0 stores the data into `ext_ctrl` with bits 12 and 13 forced to 0. All other bits are stored as written.
- R8: A write with select 5 clears each `vf_rst_evt` bit whose data bit is 1. If a VF reset request arrives in the same cycle for the same bit, the set wins.
- R9: Writes load the enable registers from the low data bits:
  - select 1 loads `rxq_en`;
  - select 2 loads `txq_en`;
  - select 3 loads `pool_rx_en`;
  - select 4 loads `pool_tx_en`.
  A VF reset request in the same cycle still clears that VF's bits.
- R10: A VF reset request and a reset-done write in the same cycle both take full effect on the same edge: queue, pool, event and interrupt updates from the reset, and the mailbox flag update from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 ext ctrl, 1 rx queues, 2 tx queues, 3 rx pools, 4 tx pools, 5 event clear |
| wr_data | input | 32 | Write data |
| vf_rst_req | input | NUM_VF | Per-VF reset request strobes |
| rxq_en | output | 2*NUM_VF | Receive queue enables |
| txq_en | output | 2*NUM_VF | Transmit queue enables |
| pool_rx_en | output | NUM_VF | Per-VF receive pool enables |
| pool_tx_en | output | NUM_VF | Per-VF transmit pool enables |
| vf_rst_evt | output | NUM_VF | Sticky VF reset events |
| pf_mbx_irq | output | 1 | Mailbox interrupt cause pulse to the PF |
| mbx_rst_inprog | output | NUM_VF | Per-VF reset-in-progress flags |
| mbx_rst_done | output | NUM_VF | Per-VF reset-done flags |
| ext_ctrl | output | 32 | Stored extended control value |

## Verification
Every output is a single register, so each result is due exactly one rising edge after the inputs that cause it. That holds for queue clears, pool clears, event bits, the interrupt pulse, mailbox flags and the stored control word. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a period after the result has settled. The interrupt is checked on the cycle after each stimulus, so a pulse that stretches past one cycle or arrives late is caught. Tests that put two updates in one cycle (request plus event clear, request plus enable write, request plus reset-done) check the combined result on that same following edge.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
  typedef enum logic [2:0] {
    SEL_EXT     = 3'd0,
    SEL_RXQ     = 3'd1,
    SEL_TXQ     = 3'd2,
    SEL_POOL_RX = 3'd3,
    SEL_POOL_TX = 3'd4,
    SEL_EVT_CLR = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/vfr_queue_ctl.sv
module vfr_queue_ctl #(
  parameter int NUM_VF = 8,
  parameter int DW     = 32,
  localparam int QW    = 2 * NUM_VF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_rxq,
  input  logic              wr_txq,
  input  logic              wr_prx,
  input  logic              wr_ptx,
  input  logic [DW-1:0]     wr_data,
  input  logic [NUM_VF-1:0] kill,
  output logic [QW-1:0]     rxq_en,
  output logic [QW-1:0]     txq_en,
  output logic [NUM_VF-1:0] pool_rx_en,
  output logic [NUM_VF-1:0] pool_tx_en
);
  // Each queue is owned by the VF equal to its index modulo NUM_VF
  for (genvar q = 0; q < QW; q++) begin : g_queue
    localparam int OWNER = q % NUM_VF;
    localparam logic RST_ON = (q == 0);
    always_ff @(posedge clk) begin
      if (rst) begin
        rxq_en[q] <= RST_ON;
        txq_en[q] <= RST_ON;
      end else begin
        if (kill[OWNER])  rxq_en[q] <= 1'b0;
        else if (wr_rxq)  rxq_en[q] <= wr_data[q];
        if (kill[OWNER])  txq_en[q] <= 1'b0;
        else if (wr_txq)  txq_en[q] <= wr_data[q];
      end
    end
  end

  for (genvar v = 0; v < NUM_VF; v++) begin : g_pool
    always_ff @(posedge clk) begin
      if (rst) begin
        pool_rx_en[v] <= 1'b0;
        pool_tx_en[v] <= 1'b0;
      end else begin
        if (kill[v])      pool_rx_en[v] <= 1'b0;
        else if (wr_prx)  pool_rx_en[v] <= wr_data[v];
        if (kill[v])      pool_tx_en[v] <= 1'b0;
        else if (wr_ptx)  pool_tx_en[v] <= wr_data[v];
      end
    end
  end
endmodule

// File: rtl/vfr_event_ctl.sv
module vfr_event_ctl #(
  parameter int NUM_VF = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [NUM_VF-1:0] clr_mask,
  input  logic [NUM_VF-1:0] req,
  output logic [NUM_VF-1:0] evt,
  output logic              irq
);
  logic [NUM_VF-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= '0;
      irq <= 1'b0;
    end else begin
      evt <= (evt & ~clr_eff) | req;
      irq <= |req;
    end
  end
endmodule

// File: rtl/vfr_mbx_flags.sv
module vfr_mbx_flags #(
  parameter int NUM_VF   = 8,
  parameter int DW       = 32,
  parameter int DONE_BIT = 14,
  parameter int SC_A_BIT = 12,
  parameter int SC_B_BIT = 13,
  localparam logic [DW-1:0] SC_MASK = (DW'(1) << SC_A_BIT) | (DW'(1) << SC_B_BIT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ext,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     ext_ctrl,
  output logic [NUM_VF-1:0] inprog,
  output logic [NUM_VF-1:0] done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_ctrl <= '0;
      inprog   <= '1;
      done     <= '0;
    end else if (wr_ext) begin
      ext_ctrl <= wr_data & ~SC_MASK;
      if (wr_data[DONE_BIT]) begin
        inprog <= '0;
        done   <= '1;
      end
    end
  end
endmodule

// File: rtl/vf_reset_ctl.sv
module vf_reset_ctl #(
  parameter int NUM_VF   = 8,
  parameter int DW       = 32,
  parameter int DONE_BIT = 14,
  parameter int SC_A_BIT = 12,
  parameter int SC_B_BIT = 13,
  localparam int QW      = 2 * NUM_VF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [NUM_VF-1:0] vf_rst_req,
  output logic [QW-1:0]     rxq_en,
  output logic [QW-1:0]     txq_en,
  output logic [NUM_VF-1:0] pool_rx_en,
  output logic [NUM_VF-1:0] pool_tx_en,
  output logic [NUM_VF-1:0] vf_rst_evt,
  output logic              pf_mbx_irq,
  output logic [NUM_VF-1:0] mbx_rst_inprog,
  output logic [NUM_VF-1:0] mbx_rst_done,
  output logic [DW-1:0]     ext_ctrl
);
  import vfr_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  logic wr_ext, wr_rxq, wr_txq, wr_prx, wr_ptx, wr_clr;
  always_comb begin
    wr_ext = wr_en && (sel == SEL_EXT);
    wr_rxq = wr_en && (sel == SEL_RXQ);
    wr_txq = wr_en && (sel == SEL_TXQ);
    wr_prx = wr_en && (sel == SEL_POOL_RX);
    wr_ptx = wr_en && (sel == SEL_POOL_TX);
    wr_clr = wr_en && (sel == SEL_EVT_CLR);
  end

  vfr_queue_ctl #(.NUM_VF(NUM_VF), .DW(DW)) u_queue (
    .clk(clk), .rst(rst),
    .wr_rxq(wr_rxq), .wr_txq(wr_txq), .wr_prx(wr_prx), .wr_ptx(wr_ptx),
    .wr_data(wr_data), .kill(vf_rst_req),
    .rxq_en(rxq_en), .txq_en(txq_en),
    .pool_rx_en(pool_rx_en), .pool_tx_en(pool_tx_en)
  );

  vfr_event_ctl #(.NUM_VF(NUM_VF)) u_event (
    .clk(clk), .rst(rst),
    .clr_en(wr_clr), .clr_mask(wr_data[NUM_VF-1:0]),
    .req(vf_rst_req), .evt(vf_rst_evt), .irq(pf_mbx_irq)
  );

  vfr_mbx_flags #(
    .NUM_VF(NUM_VF), .DW(DW), .DONE_BIT(DONE_BIT),
    .SC_A_BIT(SC_A_BIT), .SC_B_BIT(SC_B_BIT)
  ) u_mbx (
    .clk(clk), .rst(rst),
    .wr_ext(wr_ext), .wr_data(wr_data),
    .ext_ctrl(ext_ctrl), .inprog(mbx_rst_inprog), .done(mbx_rst_done)
  );
endmodule

// File: rtl/vfr_checker.sv
module vfr_checker #(
  parameter int NUM_VF   = 8,
  parameter int DW       = 32,
  parameter int DONE_BIT = 14,
  parameter int SC_A_BIT = 12,
  parameter int SC_B_BIT = 13
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [2:0]          wr_sel,
  input logic [DW-1:0]       wr_data,
  input logic [NUM_VF-1:0]   vf_rst_req,
  input logic [2*NUM_VF-1:0] rxq_en,
  input logic [2*NUM_VF-1:0] txq_en,
  input logic [NUM_VF-1:0]   pool_rx_en,
  input logic [NUM_VF-1:0]   pool_tx_en,
  input logic [NUM_VF-1:0]   vf_rst_evt,
  input logic                pf_mbx_irq,
  input logic [NUM_VF-1:0]   mbx_rst_inprog,
  input logic [NUM_VF-1:0]   mbx_rst_done,
  input logic [DW-1:0]       ext_ctrl
);
  // R1
  queue_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (|vf_rst_req) |=> (((rxq_en | txq_en) & {2{$past(vf_rst_req)}}) == '0));

  // R2
  pool_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (|vf_rst_req) |=> (((pool_rx_en | pool_tx_en) & $past(vf_rst_req)) == '0));

  // R3
  event_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|vf_rst_req) |=> ((vf_rst_evt & $past(vf_rst_req)) == $past(vf_rst_req)));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|vf_rst_req) |=> pf_mbx_irq);

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (vf_rst_req == '0) |=> !pf_mbx_irq);

  // R5
  reset_inprog_chk: assert property (@(posedge clk)
    rst |=> (&mbx_rst_inprog) && (mbx_rst_done == '0));

  // R6
  done_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd0 && wr_data[DONE_BIT]) |=>
      (mbx_rst_inprog == '0) && (&mbx_rst_done));

  // R7
  selfclr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd0) |=> !ext_ctrl[SC_A_BIT] && !ext_ctrl[SC_B_BIT]);
endmodule

bind vf_reset_ctl vfr_checker #(
  .NUM_VF(NUM_VF), .DW(DW), .DONE_BIT(DONE_BIT),
  .SC_A_BIT(SC_A_BIT), .SC_B_BIT(SC_B_BIT)
) u_vfr_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .vf_rst_req(vf_rst_req), .rxq_en(rxq_en), .txq_en(txq_en),
  .pool_rx_en(pool_rx_en), .pool_tx_en(pool_tx_en), .vf_rst_evt(vf_rst_evt),
  .pf_mbx_irq(pf_mbx_irq), .mbx_rst_inprog(mbx_rst_inprog),
  .mbx_rst_done(mbx_rst_done), .ext_ctrl(ext_ctrl)
);

// File: tb/tb_vf_reset_ctl.sv
module tb_vf_reset_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = '0;
  logic [7:0]  vf_rst_req = '0;
  logic [15:0] rxq_en, txq_en;
  logic [7:0]  pool_rx_en, pool_tx_en, vf_rst_evt, mbx_rst_inprog, mbx_rst_done;
  logic        pf_mbx_irq;
  logic [31:0] ext_ctrl;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vf_reset_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vf_rst_req(vf_rst_req), .rxq_en(rxq_en), .txq_en(txq_en),
    .pool_rx_en(pool_rx_en), .pool_tx_en(pool_tx_en), .vf_rst_evt(vf_rst_evt),
    .pf_mbx_irq(pf_mbx_irq), .mbx_rst_inprog(mbx_rst_inprog),
    .mbx_rst_done(mbx_rst_done), .ext_ctrl(ext_ctrl)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [7:0]  req;
    logic [15:0] e_rxq;
    logic [15:0] e_txq;
    logic [7:0]  e_prx;
    logic [7:0]  e_ptx;
    logic [7:0]  e_evt;
    logic        e_irq;
    logic [7:0]  e_inp;
    logic [7:0]  e_done;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R9 load rx queues
    '{1'b1, 3'd1, 32'h0000FFFF, 8'h00, 16'hFFFF, 16'h0001, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h00},
    // R9 load tx queues
    '{1'b1, 3'd2, 32'h0000FFFF, 8'h00, 16'hFFFF, 16'hFFFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h00},
    // R9 load rx pools
    '{1'b1, 3'd3, 32'h000000FF, 8'h00, 16'hFFFF, 16'hFFFF, 8'hFF, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h00},
    // R9 load tx pools
    '{1'b1, 3'd4, 32'h000000FF, 8'h00, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, 8'h00, 1'b0, 8'hFF, 8'h00},
    // R1 R2 R3 R4 reset VF2
    '{1'b0, 3'd0, 32'h00000000, 8'h04, 16'hFBFB, 16'hFBFB, 8'hFB, 8'hFB, 8'h04, 1'b1, 8'hFF, 8'h00},
    // R4 idle cycle, pulse gone
    '{1'b0, 3'd0, 32'h00000000, 8'h00, 16'hFBFB, 16'hFBFB, 8'hFB, 8'hFB, 8'h04, 1'b0, 8'hFF, 8'h00},
    // R10 reset VF0 and VF7 with reset-done write
    '{1'b1, 3'd0, 32'h00004000, 8'h81, 16'h7A7A, 16'h7A7A, 8'h7A, 8'h7A, 8'h85, 1'b1, 8'h00, 8'hFF},
    // R8 clear bits 0,2 while VF0 resets again: set wins on bit 0
    '{1'b1, 3'd5, 32'h00000005, 8'h01, 16'h7A7A, 16'h7A7A, 8'h7A, 8'h7A, 8'h81, 1'b1, 8'h00, 8'hFF},
    // R9 rx queue write with VF1 reset in same cycle
    '{1'b1, 3'd1, 32'h0000FFFF, 8'h02, 16'hFDFD, 16'h7878, 8'h78, 8'h78, 8'h83, 1'b1, 8'h00, 8'hFF},
    // R6 ext write without done bit leaves flags
    '{1'b1, 3'd0, 32'h00003FFF, 8'h00, 16'hFDFD, 16'h7878, 8'h78, 8'h78, 8'h83, 1'b0, 8'h00, 8'hFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic drive(input logic we, input logic [2:0] sel, input logic [31:0] d,
                       input logic [7:0] req);
    wr_en = we; wr_sel = sel; wr_data = d; vf_rst_req = req;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 3'd0; wr_data = '0; vf_rst_req = '0;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " rxq"}, 32'(rxq_en), 32'h0001);
    chk({tag, " txq"}, 32'(txq_en), 32'h0001);
    chk({tag, " pools"}, {16'h0, pool_rx_en, pool_tx_en}, 32'h0);
    chk({tag, " evt"}, 32'(vf_rst_evt), 32'h0);
    chk({tag, " inprog"}, 32'(mbx_rst_inprog), 32'hFF);
    chk({tag, " done"}, 32'(mbx_rst_done), 32'h0);
    chk({tag, " ext"}, ext_ctrl, 32'h0);
    chk({tag, " irq"}, 32'(pf_mbx_irq), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    check_reset_state("R5 initial");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].sel, VECS[i].data, VECS[i].req);
      chk($sformatf("R1 vec%0d rxq", i), 32'(rxq_en), 32'(VECS[i].e_rxq));
      chk($sformatf("R1 vec%0d txq", i), 32'(txq_en), 32'(VECS[i].e_txq));
      chk($sformatf("R2 vec%0d prx", i), 32'(pool_rx_en), 32'(VECS[i].e_prx));
      chk($sformatf("R2 vec%0d ptx", i), 32'(pool_tx_en), 32'(VECS[i].e_ptx));
      chk($sformatf("R3 vec%0d evt", i), 32'(vf_rst_evt), 32'(VECS[i].e_evt));
      chk($sformatf("R4 vec%0d irq", i), 32'(pf_mbx_irq), 32'(VECS[i].e_irq));
      chk($sformatf("R6 vec%0d inprog", i), 32'(mbx_rst_inprog), 32'(VECS[i].e_inp));
      chk($sformatf("R6 vec%0d done", i), 32'(mbx_rst_done), 32'(VECS[i].e_done));
    end
    // R7 last vector wrote 0x3FFF: bits 12,13 dropped
    chk("R7 ext stored", ext_ctrl, 32'h00000FFF);

    // R5 device reset in the middle of activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("R5 midrun");

    // R6 write without done bit after reset: flags unchanged
    drive(1'b1, 3'd0, 32'h00000001, 8'h00);
    chk("R6 no-done inprog", 32'(mbx_rst_inprog), 32'hFF);
    chk("R6 no-done flags done", 32'(mbx_rst_done), 32'h00);
    chk("R7 ext plain", ext_ctrl, 32'h00000001);

    // R7 R6 done bit plus both self-clearing bits
    drive(1'b1, 3'd0, 32'hA0007000, 8'h00);
    chk("R7 ext masked", ext_ctrl, 32'hA0004000);
    chk("R6 done inprog", 32'(mbx_rst_inprog), 32'h00);
    chk("R6 done flags", 32'(mbx_rst_done), 32'hFF);

    // R8 plain W1C clear of one event bit, sticky otherwise
    drive(1'b0, 3'd0, 32'h0, 8'h30);
    chk("R3 evt sticky set", 32'(vf_rst_evt), 32'h30);
    chk("R1 VF4 VF5 queues untouched bit0", 32'(rxq_en), 32'h0001);
    drive(1'b1, 3'd5, 32'h00000010, 8'h00);
    chk("R8 w1c clear", 32'(vf_rst_evt), 32'h20);
    chk("R4 irq low after idle", 32'(pf_mbx_irq), 32'h0);

    // R1 VF0 reset clears queue 0 enabled by reset
    drive(1'b0, 3'd0, 32'h0, 8'h01);
    chk("R1 queue0 rx off", 32'(rxq_en), 32'h0000);
    chk("R1 queue0 tx off", 32'(txq_en), 32'h0000);

    report();
  end
endmodule